// File: doc/BRIEF.md
# Multiply-Accumulate and Divide Unit

This block is the integer multiply/divide engine that sits beside an execution pipeline. It owns a pair of 32-bit result registers, HI and LO, which together form a 64-bit accumulator. Several operations can target them:

- a plain multiply, signed or unsigned;
- a multiply whose product is added to HI:LO;
- a multiply whose product is subtracted from HI:LO;
- an iterative divide.

A fifth form, the register-direct multiply, skips HI:LO. It returns the low word of the product on a separate result port, so it can be written straight into a register-file port.

On every multiply the unit checks whether both operands fit in 16 bits. If they do, the result arrives one cycle sooner and the next operation may follow one cycle sooner.

The pipeline drives one operation at a time on the issue port. It watches three outputs:

- `issue_ready`, which says when a new operation may be accepted.
- `issue_stall`, which says how long a register-direct multiply holds the issuing stage.
- `hilo_pending`, which tells a reader of HI or LO to wait until the awaited result has landed.

The register file and pipeline control are outside this block.

Top module: `muldiv_unit`

## Requirements
- R1: After synchronous reset, `hi_q` and `lo_q` are zero, `issue_ready` is 1, and `hilo_pending`, `issue_stall` and `gpr_valid` are 0.
- R2: An operation is accepted on a clock edge where `op_valid` and `issue_ready` are both 1. `op_kind` selects the operation: 0 multiply into HI:LO, 1 multiply-add, 2 multiply-subtract, 3 register-direct multiply, 4 divide. `op_unsigned`=1 selects the unsigned form. A plain multiply leaves the full 64-bit product in HI (upper word) and LO (lower word).
- R3: An operand counts as narrow under two rules. For signed forms, bits 31..16 must all equal bit 15. For unsigned forms, bits 31..16 must be zero. If both operands are narrow, a multiply's result is visible 3 cycles after the accepting edge; otherwise it is visible 4 cycles after.
- R4: After a multiply is accepted, `issue_ready` stays low for 1 cycle (narrow) or 2 cycles (wide). After a divide it stays low for 35 cycles, so the issue rates are 2, 3 and 36 cycles.
- R5: Multiply-add sets HI:LO to HI:LO plus the 64-bit product, and multiply-subtract sets it to HI:LO minus the product, both modulo 2^64. An operation issued as soon as allowed accumulates onto the result of the one before it.
- R6: A register-direct multiply pulses `gpr_valid` for exactly one cycle, with the low 32 bits of the product on `gpr_data`, at the same latency as R3. It leaves HI and LO unchanged and does not raise `hilo_pending`.
- R7: After a register-direct multiply is accepted, `issue_stall` is high for 1 cycle (narrow) or 2 cycles (wide). `issue_stall` is never high while `issue_ready` is high.
- R8: A divide writes the quotient to LO and the remainder to HI 36 cycles after acceptance. The signed form truncates toward zero, and its remainder takes the sign of the dividend.
- R9: A divide by zero finishes in the same 36 cycles and the unit is ready again afterwards; the values it leaves in HI and LO are unspecified.
- R10: The unit ignores `op_valid` while `issue_ready` is low. It also ignores any `op_kind` from 5 to 7. In both cases HI, LO and the timing outputs are untouched.
- R11: `hilo_pending` is high from the accepting edge of a HI/LO-writing operation until its result is visible in `hi_q`/`lo_q`. HI and LO change only on an edge where `hilo_pending` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | New operation offered |
| op_kind | input | 3 | Operation select (see R2) |
| op_unsigned | input | 1 | 1 selects the unsigned form |
| op_a | input | 32 | First operand / dividend |
| op_b | input | 32 | Second operand / divisor |
| issue_ready | output | 1 | A new operation may be accepted |
| issue_stall | output | 1 | Issue stage hold after a register-direct multiply |
| hilo_pending | output | 1 | A HI/LO result is still in flight |
| hi_q | output | 32 | HI register |
| lo_q | output | 32 | LO register |
| gpr_valid | output | 1 | One-cycle strobe for the register-direct result |
| gpr_data | output | 32 | Low word of the register-direct product |

## Verification
Operand pairs are chosen on both sides of the narrow boundary in each signedness. Examples are 0xFFFF8000 against 0x00008000, and 0x0000FFFF against 0xFFFF8000. These separate the sign-extension rule from the zero-extension rule, and the latency and repeat counts each pattern yields separate the 3/2 timing from the 4/3 timing.

Accumulate and subtract forms are issued both in isolation and back to back at the earliest allowed cycle, mixing narrow and wide operands. This shows that each one folds onto its predecessor's result, even when a short operation follows a long one.

Divides cover:
- a signed dividend with a negative result;
- an unsigned dividend with its top bit set;
- a zero divisor;
- a flood of offers while the unit is busy.

The register-direct multiply is checked for its stall length, its single strobe, and the untouched HI:LO.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    KIND_MULT = 3'd0,
    KIND_MADD = 3'd1,
    KIND_MSUB = 3'd2,
    KIND_MULR = 3'd3,
    KIND_DIV  = 3'd4
  } mdu_kind_e;

  // what the multiply path does with its product once it retires
  typedef enum logic [1:0] {
    ACT_LOAD = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2,
    ACT_GPR  = 2'd3
  } mdu_act_e;

  function automatic logic kind_known(input logic [2:0] k);
    return k <= KIND_DIV;
  endfunction

  function automatic mdu_act_e kind_to_act(input logic [2:0] k);
    case (k)
      KIND_MADD: return ACT_ADD;
      KIND_MSUB: return ACT_SUB;
      KIND_MULR: return ACT_GPR;
      default:   return ACT_LOAD;
    endcase
  endfunction

endpackage

// File: rtl/mdu_narrow_chk.sv
// Flags an operand that is the extension of its low NW bits.
module mdu_narrow_chk #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic [W-1:0] val,
  input  logic         sgn,
  output logic         fits
);
  logic [W-NW:0] upper_s;
  logic [W-NW-1:0] upper_u;

  assign upper_s = val[W-1:NW-1];
  assign upper_u = val[W-1:NW];
  assign fits = sgn ? ((&upper_s) | ~(|upper_s)) : ~(|upper_u);
endmodule

// File: rtl/mdu_mul_pipe.sv
// Multiplier plus a delay line of retire slots; an issued product enters
// the slot whose distance to the retire point equals its latency.
module mdu_mul_pipe
  import mdu_pkg::*;
#(
  parameter int W         = 32,
  parameter int LAT_SHORT = 3,
  parameter int LAT_LONG  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic           short_op,
  input  logic           sgn,
  input  mdu_act_e       act,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           cm_vld,
  output mdu_act_e       cm_act,
  output logic [2*W-1:0] cm_prod,
  output logic           pend_hilo
);
  localparam int DEPTH = LAT_LONG;
  localparam int PW    = 2 * W;

  typedef struct packed {
    logic          vld;
    mdu_act_e      act;
    logic [PW-1:0] prod;
  } slot_t;

  logic [PW-1:0] ext_a, ext_b, prod;
  slot_t         ins;
  int unsigned   lat_sel;
  slot_t         stage_q [1:DEPTH];
  logic [DEPTH:1] pend_v;

  assign ext_a   = {{W{sgn & a[W-1]}}, a};
  assign ext_b   = {{W{sgn & b[W-1]}}, b};
  assign prod    = ext_a * ext_b;
  assign ins     = '{vld: 1'b1, act: act, prod: prod};
  assign lat_sel = short_op ? LAT_SHORT : LAT_LONG;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    slot_t feed;
    if (k < DEPTH) begin : g_shift
      assign feed = stage_q[k+1];
    end else begin : g_head
      assign feed = '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[k] <= '0;
      end else if (issue && (lat_sel == k)) begin
        stage_q[k] <= ins;
      end else begin
        stage_q[k] <= feed;
      end
    end

    assign pend_v[k] = stage_q[k].vld && (stage_q[k].act != ACT_GPR);
  end

  assign cm_vld    = stage_q[1].vld;
  assign cm_act    = stage_q[1].act;
  assign cm_prod   = stage_q[1].prod;
  assign pend_hilo = |pend_v;
endmodule

// File: rtl/mdu_divider.sv
// Restoring divider, one quotient bit per cycle, fixed total duration.
module mdu_divider #(
  parameter int W      = 32,
  parameter int CYCLES = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] ITER_END = CW'(CYCLES - W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  acc_q, quo_q, dvs_q;
  logic          negq_q, negr_q;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    shifted, diff;
  logic          take;

  assign a_mag   = (sgn && a[W-1]) ? (~a + 1'b1) : a;
  assign b_mag   = (sgn && b[W-1]) ? (~b + 1'b1) : b;
  assign shifted = {acc_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign take    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CNT_LOAD;
      acc_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      negq_q <= sgn & (a[W-1] ^ b[W-1]);
      negr_q <= sgn & a[W-1];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q > ITER_END) begin
        acc_q <= take ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
      end
    end
  end

  assign busy = cnt_q != '0;
  assign fin  = cnt_q == CNT_ONE;
  assign quo  = negq_q ? (~quo_q + 1'b1) : quo_q;
  assign rem  = negr_q ? (~acc_q + 1'b1) : acc_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W           = 32,
  parameter int NARROW      = 16,
  parameter int LAT_SHORT   = 3,
  parameter int LAT_LONG    = 4,
  parameter int REP_SHORT   = 2,
  parameter int REP_LONG    = 3,
  parameter int STALL_SHORT = 1,
  parameter int STALL_LONG  = 2,
  parameter int DIV_CYCLES  = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic         op_unsigned,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         issue_ready,
  output logic         issue_stall,
  output logic         hilo_pending,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic         gpr_valid,
  output logic [W-1:0] gpr_data
);
  localparam int RW = $clog2(DIV_CYCLES);
  localparam int SW = $clog2(STALL_LONG + 1);
  localparam logic [RW-1:0] REP_DIV_LD   = RW'(DIV_CYCLES - 1);
  localparam logic [RW-1:0] REP_SHORT_LD = RW'(REP_SHORT - 1);
  localparam logic [RW-1:0] REP_LONG_LD  = RW'(REP_LONG - 1);
  localparam logic [SW-1:0] STL_SHORT_LD = SW'(STALL_SHORT);
  localparam logic [SW-1:0] STL_LONG_LD  = SW'(STALL_LONG);

  logic           sgn, accept, mul_go, div_go, gpr_go;
  logic           a_fits, b_fits, short_op;
  logic [RW-1:0]  rep_q;
  logic [SW-1:0]  stall_q;
  logic           cm_vld, pend_mul;
  mdu_act_e       cm_act;
  logic [2*W-1:0] cm_prod, hilo_cat, hilo_add, hilo_sub;
  logic           div_busy, div_fin;
  logic [W-1:0]   div_quo, div_rem;

  assign sgn      = ~op_unsigned;
  assign accept   = op_valid && issue_ready && kind_known(op_kind);
  assign div_go   = accept && (op_kind == KIND_DIV);
  assign mul_go   = accept && (op_kind != KIND_DIV);
  assign gpr_go   = accept && (op_kind == KIND_MULR);
  assign short_op = a_fits && b_fits;

  mdu_narrow_chk #(.W(W), .NW(NARROW)) u_fit_a (.val(op_a), .sgn(sgn), .fits(a_fits));
  mdu_narrow_chk #(.W(W), .NW(NARROW)) u_fit_b (.val(op_b), .sgn(sgn), .fits(b_fits));

  mdu_mul_pipe #(.W(W), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_mul (
    .clk(clk), .rst(rst), .issue(mul_go), .short_op(short_op), .sgn(sgn),
    .act(kind_to_act(op_kind)), .a(op_a), .b(op_b),
    .cm_vld(cm_vld), .cm_act(cm_act), .cm_prod(cm_prod), .pend_hilo(pend_mul)
  );

  mdu_divider #(.W(W), .CYCLES(DIV_CYCLES)) u_div (
    .clk(clk), .rst(rst), .start(div_go), .sgn(sgn), .a(op_a), .b(op_b),
    .busy(div_busy), .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  // repeat-rate and issue-stall counters
  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q   <= '0;
      stall_q <= '0;
    end else begin
      if (div_go)           rep_q <= REP_DIV_LD;
      else if (mul_go)      rep_q <= short_op ? REP_SHORT_LD : REP_LONG_LD;
      else if (rep_q != '0) rep_q <= rep_q - 1'b1;

      if (gpr_go)             stall_q <= short_op ? STL_SHORT_LD : STL_LONG_LD;
      else if (stall_q != '0) stall_q <= stall_q - 1'b1;
    end
  end

  assign issue_ready  = rep_q == '0;
  assign issue_stall  = stall_q != '0;
  assign hilo_pending = pend_mul | div_busy;

  assign hilo_cat = {hi_q, lo_q};
  assign hilo_add = hilo_cat + cm_prod;
  assign hilo_sub = hilo_cat - cm_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      gpr_valid <= 1'b0;
      gpr_data  <= '0;
    end else begin
      gpr_valid <= 1'b0;
      if (div_fin) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end else if (cm_vld) begin
        case (cm_act)
          ACT_LOAD: {hi_q, lo_q} <= cm_prod;
          ACT_ADD:  {hi_q, lo_q} <= hilo_add;
          ACT_SUB:  {hi_q, lo_q} <= hilo_sub;
          default: begin
            gpr_valid <= 1'b1;
            gpr_data  <= cm_prod[W-1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [2:0]   op_kind,
  input logic         issue_ready,
  input logic         issue_stall,
  input logic         hilo_pending,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         gpr_valid
);
  logic acc_any, acc_div, acc_gpr;
  assign acc_any = op_valid && issue_ready && (op_kind <= 3'd4);
  assign acc_div = acc_any && (op_kind == 3'd4);
  assign acc_gpr = acc_any && (op_kind == 3'd3);

  AST_HILO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hilo_pending |=> ($stable(hi_q) && $stable(lo_q))); // R11

  AST_STALL_INSIDE_REPEAT: assert property (@(posedge clk) disable iff (rst)
    issue_stall |-> !issue_ready); // R7

  AST_REPEAT_GAP: assert property (@(posedge clk) disable iff (rst)
    acc_any |=> !issue_ready); // R4

  AST_DIV_PENDING: assert property (@(posedge clk) disable iff (rst)
    acc_div |=> hilo_pending); // R8

  AST_DIRECT_STALLS: assert property (@(posedge clk) disable iff (rst)
    acc_gpr |=> issue_stall); // R7

  AST_GPR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    gpr_valid |=> !gpr_valid); // R6

  AST_DIRECT_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
    (acc_gpr && !hilo_pending) |=> !hilo_pending); // R6
endmodule

bind muldiv_unit mdu_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .issue_ready(issue_ready), .issue_stall(issue_stall),
  .hilo_pending(hilo_pending), .hi_q(hi_q), .lo_q(lo_q), .gpr_valid(gpr_valid)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_MULT = 3'd0, K_MADD = 3'd1, K_MSUB = 3'd2,
                         K_MULR = 3'd3, K_DIV = 3'd4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        op_valid = 1'b0, op_unsigned = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        issue_ready, issue_stall, hilo_pending, gpr_valid;
  logic [31:0] hi_q, lo_q, gpr_data;

  muldiv_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_unsigned(op_unsigned), .op_a(op_a), .op_b(op_b),
    .issue_ready(issue_ready), .issue_stall(issue_stall),
    .hilo_pending(hilo_pending), .hi_q(hi_q), .lo_q(lo_q),
    .gpr_valid(gpr_valid), .gpr_data(gpr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [63:0] m_acc = '0;

  typedef struct {
    int          due;
    bit          g;
    logic [31:0] hi, lo, gp;
    string       req;
  } exp_t;
  exp_t sbq[$];

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic bit narrow(logic [31:0] v, bit uns);
    return uns ? (v[31:16] == 16'h0) : (v[31:16] == {16{v[15]}});
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sbq.size() != 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      check(e.req, "hi_q", hi_q, e.hi);
      check(e.req, "lo_q", lo_q, e.lo);
      if (e.g) begin
        check(e.req, "gpr_valid", gpr_valid, 1);
        check(e.req, "gpr_data", gpr_data, e.gp);
      end
    end
  end

  // driver: issues one operation and pushes its expectation
  task automatic issue(logic [2:0] kind, bit uns, logic [31:0] a, logic [31:0] b, string req);
    exp_t e;
    logic [63:0] p;
    int lat;
    bit push = 1;
    while (!issue_ready) @(negedge clk);
    lat = (narrow(a, uns) && narrow(b, uns)) ? 3 : 4;
    if (kind == K_DIV) lat = 36;
    if (uns) p = {32'h0, a} * {32'h0, b};
    else     p = 64'(longint'(signed'(a)) * longint'(signed'(b)));
    e.g = 0; e.gp = '0; e.req = req; e.due = cyc + 1 + lat;
    case (kind)
      K_MULT: m_acc = p;
      K_MADD: m_acc = m_acc + p;
      K_MSUB: m_acc = m_acc - p;
      K_MULR: begin e.g = 1; e.gp = p[31:0]; end
      default: begin
        if (b == 0) push = 0;
        else if (uns) m_acc = {a % b, a / b};
        else begin
          int sa = a, sb = b;
          m_acc = {32'(sa % sb), 32'(sa / sb)};
        end
      end
    endcase
    e.hi = m_acc[63:32]; e.lo = m_acc[31:0];
    if (push) sbq.push_back(e);
    op_kind = kind; op_unsigned = uns; op_a = a; op_b = b; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // timing probe for an isolated operation, starting the cycle after issue
  task automatic measure(int exp_p, int exp_r, int exp_s, int exp_g, string req);
    int np = 0, nr = 0, ns = 0, ng = 0, gi = -1;
    for (int j = 0; j < 40; j++) begin
      if (hilo_pending) np++;
      if (!issue_ready) nr++;
      if (issue_stall) ns++;
      if (gpr_valid) begin ng++; if (gi < 0) gi = j; end
      @(negedge clk);
    end
    check(req, "hilo_pending cycles", np, exp_p);
    check("R4", "issue_ready low cycles", nr, exp_r);
    check("R7", "issue_stall cycles", ns, exp_s);
    check("R6", "gpr_valid pulses", ng, (exp_g < 0) ? 0 : 1);
    check("R6", "gpr_valid position", gi, exp_g);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "hi_q", hi_q, 0);
    check("R1", "lo_q", lo_q, 0);
    check("R1", "issue_ready", issue_ready, 1);
    check("R1", "hilo_pending", hilo_pending, 0);
    check("R1", "issue_stall", issue_stall, 0);
    check("R1", "gpr_valid", gpr_valid, 0);

    // R2 R3: narrow signed multiply, wide unsigned multiply
    issue(K_MULT, 0, 32'hFFFFFFFD, 32'd7, "R2");
    measure(3, 1, 0, -1, "R3");
    issue(K_MULT, 1, 32'h12345678, 32'h9ABCDEF0, "R2");
    measure(4, 2, 0, -1, "R3");
    // R3 boundaries of the narrow rule
    issue(K_MULT, 0, 32'hFFFF8000, 32'h00007FFF, "R3");
    measure(3, 1, 0, -1, "R3");
    issue(K_MULT, 0, 32'h00008000, 32'd2, "R3");
    measure(4, 2, 0, -1, "R3");
    issue(K_MULT, 1, 32'h0000FFFF, 32'h0000FFFF, "R3");
    measure(3, 1, 0, -1, "R3");
    issue(K_MULT, 1, 32'hFFFF8000, 32'd1, "R3");
    measure(4, 2, 0, -1, "R3");

    // R5 isolated accumulate and subtract
    issue(K_MADD, 0, 32'd5, 32'd6, "R5");
    measure(3, 1, 0, -1, "R5");
    issue(K_MSUB, 0, 32'h00010000, 32'h00010000, "R5");
    measure(4, 2, 0, -1, "R5");

    // R5 back to back at the earliest allowed cycles
    issue(K_MADD, 0, 32'd5, 32'd6, "R5");
    issue(K_MADD, 1, 32'h00012345, 32'h00054321, "R5");
    issue(K_MSUB, 0, 32'hFFFFFFF9, 32'd9, "R5");
    issue(K_MADD, 1, 32'h0000FFFF, 32'h00000003, "R5");
    drain();

    // R6 R7 register-direct multiply, narrow and wide
    issue(K_MULR, 0, 32'd100, 32'hFFFFFFFE, "R6");
    measure(0, 1, 1, 3, "R6");
    issue(K_MULR, 1, 32'h89ABCDEF, 32'h00000013, "R6");
    measure(0, 2, 2, 4, "R6");

    // R8 divide, signed and unsigned
    issue(K_DIV, 0, 32'hFFFFFF9C, 32'd7, "R8");
    measure(36, 35, 0, -1, "R8");
    issue(K_DIV, 1, 32'hFFFFFFF0, 32'd3, "R8");
    measure(36, 35, 0, -1, "R8");

    // R9 divide by zero keeps normal timing, unit usable afterwards
    issue(K_DIV, 0, 32'd1234, 32'd0, "R9");
    measure(36, 35, 0, -1, "R9");
    issue(K_MULT, 0, 32'd11, 32'd13, "R9");
    measure(3, 1, 0, -1, "R9");

    // R10 offers while busy are ignored
    issue(K_DIV, 1, 32'd1000, 32'd7, "R10");
    op_kind = K_MULT; op_unsigned = 1'b1; op_a = 32'd3; op_b = 32'd3; op_valid = 1'b1;
    repeat (5) @(negedge clk);
    op_valid = 1'b0;
    drain();
    repeat (5) @(negedge clk);
    check("R10", "hi_q after busy offers", hi_q, m_acc[63:32]);
    check("R10", "lo_q after busy offers", lo_q, m_acc[31:0]);

    // R10 undefined kind ignored
    op_kind = 3'd5; op_a = 32'd9; op_b = 32'd9; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R10", "issue_ready after undefined kind", issue_ready, 1);
    check("R10", "hilo_pending after undefined kind", hilo_pending, 0);
    repeat (5) @(negedge clk);
    check("R10", "hi_q after undefined kind", hi_q, m_acc[63:32]);
    check("R10", "lo_q after undefined kind", lo_q, m_acc[31:0]);

    check("R11", "scoreboard left over", sbq.size(), 0);
    finish_run();
  end
endmodule